// File: doc/BRIEF.md
# Privilege-Aliased Trace Control Register

This unit keeps the control state for a branch-trace recording feature in two 64-bit registers. One is the machine control word. The other is a separate control word for a virtualized supervisor. Software reaches them through three CSR addresses: machine, supervisor and virtual-supervisor. All three share a single read-modify-write port that carries a new value and a per-bit write mask.

On each valid access the address and the current virtualization state pick two things: a backing register and a legal-bit mask. The old value comes back ANDed with that mask, and only the requested bits that the mask allows take the new value.

The supervisor address works in one of two ways:
- With virtualization off, it is a narrowed view of the machine register. Machine-only bits are not visible through it and cannot be changed through it.
- With virtualization on, it is redirected to the virtual-supervisor register.

Permission checking and the meaning of individual fields are handled elsewhere. Here, every bit is either writable or read-only zero.

Top module: `trace_ctl_regs`

## Requirements
- R1: After reset both registers are zero, so every read returns zero.
- R2: The machine address (12'h34E) uses the machine register with the parameter MACH_MASK for both read and write.
- R3: The supervisor address (12'h14E) with virt_i low uses the machine register with SUPV_MASK. Bits outside SUPV_MASK are read as zero and are never altered.
- R4: The supervisor address with virt_i high, and the virtual-supervisor address (12'h24E) in either virtualization state, use the virtual-supervisor register with VSUP_MASK.
- R5: rdata_o equals the selected register ANDed with the selected mask, taken before the write of the same cycle. It is combinational.
- R6: On the clock edge of a valid cycle, a bit takes wdata_i only if both wmask_i and the selected mask are set for that bit. All other bits hold their value.
- R7: With valid_i low, or with any other address, no register changes, and rdata_o is zero.
- R8: A hit is flagged on hit_o: it is high when valid_i is high and the address is one of the three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access strobe |
| addr_i | input | 12 | CSR address |
| virt_i | input | 1 | Virtualization state |
| wdata_i | input | 64 | New value |
| wmask_i | input | 64 | Requested write mask |
| rdata_o | output | 64 | Masked old value |
| hit_o | output | 1 | Address decoded |

## Verification
The bench drives the supervisor address with all-ones data and mask and then checks that machine-only bits kept their values. A design that routed this access through the machine mask would corrupt those bits. It switches virtualization between consecutive supervisor accesses. A design that ignored the redirect would read the machine word, or write it, where the virtual word belongs. Reads are taken in the same cycle as a write, so a design that returned the new value would miscompare. Partial write masks are used to catch a design that writes every legal bit regardless of the request.

// File: rtl/trace_ctl_pkg.sv
package trace_ctl_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned AW   = 12;
  typedef enum logic [1:0] {SEL_NONE, SEL_MACH, SEL_SUPV, SEL_VSUP} sel_e;
  localparam logic [AW-1:0] ADDR_MACH = 12'h34E;
  localparam logic [AW-1:0] ADDR_SUPV = 12'h14E;
  localparam logic [AW-1:0] ADDR_VSUP = 12'h24E;
endpackage

// File: rtl/trace_ctl_decode.sv
module trace_ctl_decode
  import trace_ctl_pkg::*;
(
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          virt_i,
  output sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (valid_i) begin
      unique case (addr_i)
        ADDR_MACH: sel_o = SEL_MACH;
        ADDR_SUPV: sel_o = virt_i ? SEL_VSUP : SEL_SUPV;
        ADDR_VSUP: sel_o = SEL_VSUP;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/trace_ctl_rmw_reg.sv
module trace_ctl_rmw_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] legal_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] wmask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] eff;
  assign eff = wmask_i & legal_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[b] <= 1'b0;
      else if (en_i && eff[b])    q_o[b] <= wdata_i[b];
    end
  end
endmodule

// File: rtl/trace_ctl_regs.sv
module trace_ctl_regs
  import trace_ctl_pkg::*;
#(
  parameter logic [63:0] MACH_MASK = 64'h0000_0003_FFFF_F3FF,
  parameter logic [63:0] SUPV_MASK = 64'h0000_0003_FFFF_F007,
  parameter logic [63:0] VSUP_MASK = 64'h0000_0003_FFFF_F007
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [11:0]   addr_i,
  input  logic          virt_i,
  input  logic [63:0]   wdata_i,
  input  logic [63:0]   wmask_i,
  output logic [63:0]   rdata_o,
  output logic          hit_o
);
  sel_e        sel;
  logic [63:0] mach_q, vsup_q, legal, src;

  trace_ctl_decode u_dec (
    .valid_i(valid_i), .addr_i(addr_i), .virt_i(virt_i), .sel_o(sel)
  );

  always_comb begin
    unique case (sel)
      SEL_MACH: begin legal = MACH_MASK; src = mach_q; end
      SEL_SUPV: begin legal = SUPV_MASK; src = mach_q; end
      SEL_VSUP: begin legal = VSUP_MASK; src = vsup_q; end
      default:  begin legal = '0;        src = '0;     end
    endcase
  end

  trace_ctl_rmw_reg #(.W(XLEN)) u_mach (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(sel == SEL_MACH || sel == SEL_SUPV),
    .legal_i(legal), .wdata_i(wdata_i), .wmask_i(wmask_i), .q_o(mach_q)
  );

  trace_ctl_rmw_reg #(.W(XLEN)) u_vsup (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(sel == SEL_VSUP),
    .legal_i(legal), .wdata_i(wdata_i), .wmask_i(wmask_i), .q_o(vsup_q)
  );

  assign rdata_o = src & legal;
  assign hit_o   = (sel != SEL_NONE);
endmodule

module trace_ctl_regs_chk #(
  parameter logic [63:0] MACH_MASK = '0,
  parameter logic [63:0] SUPV_MASK = '0,
  parameter logic [63:0] VSUP_MASK = '0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [11:0] addr_i,
  input logic        virt_i,
  input logic [63:0] wdata_i,
  input logic [63:0] wmask_i,
  input logic [63:0] rdata_o,
  input logic        hit_o,
  input logic [63:0] mach_q,
  input logic [63:0] vsup_q
);
  logic sup_phys, to_vsup, to_mach_any;
  assign sup_phys    = valid_i && addr_i == 12'h14E && !virt_i;
  assign to_vsup     = valid_i && (addr_i == 12'h24E || (addr_i == 12'h14E && virt_i));
  assign to_mach_any = valid_i && (addr_i == 12'h34E || sup_phys);

  AST_SUPV_KEEPS_MACH_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_phys |=> ((mach_q & ~SUPV_MASK) == ($past(mach_q) & ~SUPV_MASK))); // R3
  AST_VSUP_LEAVES_MACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_vsup |=> $stable(mach_q)); // R4
  AST_MACH_LEAVES_VSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_mach_any |=> $stable(vsup_q)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> ($stable(mach_q) && $stable(vsup_q))); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rdata_o == '0); // R7
  AST_VSUP_READ_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_vsup |-> (rdata_o & ~VSUP_MASK) == '0); // R5
endmodule

bind trace_ctl_regs trace_ctl_regs_chk #(
  .MACH_MASK(MACH_MASK), .SUPV_MASK(SUPV_MASK), .VSUP_MASK(VSUP_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
  .virt_i(virt_i), .wdata_i(wdata_i), .wmask_i(wmask_i), .rdata_o(rdata_o),
  .hit_o(hit_o), .mach_q(mach_q), .vsup_q(vsup_q)
);

// File: tb/tb_trace_ctl_regs.sv
module tb_trace_ctl_regs;
  localparam logic [63:0] MM = 64'h0000_0003_FFFF_F3FF;
  localparam logic [63:0] SM = 64'h0000_0003_FFFF_F007;
  localparam logic [63:0] VM = 64'h0000_0003_FFFF_F007;

  logic clk = 0, rst_n = 0, valid = 0, virt = 0, hit;
  logic [11:0] addr = 0;
  logic [63:0] wdata = 0, wmask = 0, rdata;
  int vec = 0, bad = 0;
  logic [63:0] m_ref = 0, v_ref = 0;

  always #4 clk = ~clk;

  trace_ctl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .addr_i(addr), .virt_i(virt),
    .wdata_i(wdata), .wmask_i(wmask), .rdata_o(rdata), .hit_o(hit)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference model: one access, checked before the edge, then state updated
  task automatic acc(string req, logic v, logic [11:0] a, logic vi,
                     logic [63:0] d, logic [63:0] m);
    logic [63:0] lg, old;
    int tgt; // 0 none 1 mach 2 vsup
    @(negedge clk);
    valid = v; addr = a; virt = vi; wdata = d; wmask = m;
    tgt = 0; lg = 0;
    if (v) begin
      if (a == 12'h34E) begin tgt = 1; lg = MM; end
      else if (a == 12'h14E && !vi) begin tgt = 1; lg = SM; end
      else if (a == 12'h24E || a == 12'h14E) begin tgt = 2; lg = VM; end
    end
    old = (tgt == 1) ? m_ref : (tgt == 2) ? v_ref : 64'h0;
    #1;
    chk(req, rdata, old & lg);
    chk({req, "_hit"}, {63'h0, hit}, {63'h0, tgt != 0});
    if (tgt == 1) m_ref = (m_ref & ~(m & lg)) | (d & m & lg);
    if (tgt == 2) v_ref = (v_ref & ~(m & lg)) | (d & m & lg);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        bad++; vec++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    acc("R1", 1, 12'h34E, 0, 0, 0);
    acc("R1", 1, 12'h24E, 0, 0, 0);
    // R2 full write machine
    acc("R2", 1, 12'h34E, 0, '1, '1);
    acc("R2", 1, 12'h34E, 0, 0, 0);
    // R3 supervisor view clears its bits only
    acc("R3", 1, 12'h14E, 0, 0, '1);
    acc("R3", 1, 12'h34E, 0, 0, 0);
    acc("R3", 1, 12'h14E, 0, '1, '1);
    // R4 redirect with virt on, and vs address
    acc("R4", 1, 12'h14E, 1, 64'hA5A5_A5A5_A5A5_A5A5, '1);
    acc("R4", 1, 12'h24E, 0, 0, 0);
    acc("R4", 1, 12'h34E, 0, 0, 0);
    // R5 read returns old value during write
    acc("R5", 1, 12'h24E, 1, 0, '1);
    acc("R5", 1, 12'h24E, 1, 0, 0);
    // R6 partial masks
    acc("R6", 1, 12'h34E, 0, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0FF0);
    acc("R6", 1, 12'h34E, 0, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F);
    acc("R6", 1, 12'h34E, 0, 0, 0);
    // R7 idle and unknown address
    acc("R7", 0, 12'h34E, 0, 0, '1);
    acc("R7", 1, 12'h123, 0, 0, '1);
    acc("R7", 1, 12'h34E, 0, 0, 0);
    // R8 hit across addresses with virt toggling
    for (int i = 0; i < 40; i++)
      acc("R8", (i % 5) != 0, (i % 3 == 0) ? 12'h34E : (i % 3 == 1) ? 12'h14E : 12'h24E,
          i[1], {32'h9E37_79B9 * i, 32'h85EB_CA6B ^ i}, {32'hFFFF_0000 >> (i % 7), 32'hC3C3_C3C3 ^ i});
    acc("R8", 1, 12'h34E, 0, 0, 0);
    acc("R8", 1, 12'h24E, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule